// File: doc/BRIEF.md
# Parallel CRC Engine with Optional Pre-Mix Stage

This block computes a cyclic redundancy check over a message that arrives as a stream of fixed-width words, one word per clock when the strobe is high. The generator polynomial, the starting value, the word width and the order in which the bits of a word enter the division are all fixed by parameters. The register is as wide as the polynomial degree, and the register value is the output.

The polynomial parameter is written in full, with the leading term included (the common 16-bit CCITT generator is `17'h11021`). The seed parameter is one bit wider than the register; its top bit has no effect. An optional speed setting splits the update into two registered steps. The first step folds the incoming word into a degree-wide mix term. The second step merges that mix term into the register. This shortens the logic path, adds one clock of latency and still accepts a word every clock. A second option selects the augmented (zero-padded) division. In that form the message must be followed by degree-many zero bits before the register holds the checksum.

Top module: `crc_par_engine`

## Requirements
- R1: A high `rst` or `init` at a clock edge loads the register with the low DEG bits of SEED and clears `crc_vld`. The top bit of SEED does not change the loaded value.
- R2: In the direct form, with MSB_FIRST=1, the result equals bit-serial polynomial division in which each input bit is XORed with the register's top bit to form the feedback. With POLY=17'h11021 and an effective seed of 16'hFFFF, the 32-bit word 32'h12345670 gives 16'hB1E4.
- R3: Every cycle with `din_vld` high and `init` low consumes exactly one DW-bit word. While `din_vld` is low, the register holds its value.
- R4: With MSB_FIRST=1, `din[DW-1]` enters the division first and `din[0]` last. With MSB_FIRST=0, `din[0]` enters first.
- R5: With SPEED=1, a word shows up in `crc_out` two clock edges after it is presented, which is one edge later than with SPEED=0. Words presented on consecutive cycles are all absorbed.
- R6: `crc_vld` is high in exactly the cycles in which `crc_out` has just absorbed a word. Without SPEED that word was presented one edge earlier; with SPEED it was presented two edges earlier.
- R7: With AUGMENTED=1 and an effective seed of zero, feeding a message followed by DEG zero bits leaves the same value as the direct-form CRC of the message with a zero seed.
- R8: `init` has priority over data. A word presented in the same cycle as `init` is dropped. With SPEED=1, a word still held in the mix stage when `init` arrives is also dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous restart of the register from the seed |
| din_vld | input | 1 | High when `din` carries a message word |
| din | input | DW | Message word |
| crc_out | output | DEG | Current CRC register value |
| crc_vld | output | 1 | High when `crc_out` has just absorbed a word |

## Verification
The main function is exercised in several ways, each against a bit-serial reference model:
- A 32-bit, MSB-first, single-stage instance walks a table of words back to back. The table holds zeros, all ones, single end bits, alternating patterns and the known 0x12345670 vector. It tells apart errors in feedback taps, seed handling and per-word bit order.
- A byte-wide, LSB-first instance with a 32-bit generator and the speed stage is streamed without gaps. It tells apart the two bit orders and checks the extra clock of latency at full throughput.
- A 1-bit augmented instance is fed a message followed by zero padding. Its result is compared with the direct-form result, which separates the two division forms.
- Directed cases cover `init` arriving together with a word and `init` arriving while a word sits in the mix stage.

// File: rtl/crc_par_pkg.sv
package crc_par_pkg;
  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] vec_t;

  // Advance a CRC state over dw bits of data, one bit per iteration.
  function automatic vec_t step_bits(vec_t st, vec_t data, vec_t taps,
                                     int deg, int dw, bit msb_first, bit aug);
    vec_t mask;
    logic b;
    logic fb;
    logic [5:0] top;
    logic [5:0] idx;
    mask = (vec_t'(1) << deg) - vec_t'(1);
    top  = 6'(deg - 1);
    for (int i = 0; i < MAXW; i++) begin
      if (i < dw) begin
        idx = msb_first ? 6'(dw - 1 - i) : 6'(i);
        b   = data[idx];
        fb  = st[top];
        if (!aug) fb = fb ^ b;
        st = (st << 1) & mask;
        if (aug) st[0] = b;
        if (fb) st = st ^ (taps & mask);
      end
    end
    return st;
  endfunction
endpackage

// File: rtl/crc_premix.sv
module crc_premix #(
  parameter int DEG = 16,
  parameter int DW = 8,
  parameter logic [DEG:0] POLY = 17'h11021,
  parameter bit MSB_FIRST = 1'b1,
  parameter bit AUGMENTED = 1'b0,
  parameter bit SPEED = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init,
  input  logic           din_vld,
  input  logic [DW-1:0]  din,
  output logic [DEG-1:0] mix,
  output logic           mix_vld
);
  import crc_par_pkg::*;
  localparam vec_t TAPS = MAXW'(POLY[DEG-1:0]);

  logic [DEG-1:0] mix_d;

  // Contribution of the word alone, starting from an all-zero state.
  always_comb
    mix_d = DEG'(step_bits('0, MAXW'(din), TAPS, DEG, DW, MSB_FIRST, AUGMENTED));

  generate
    if (SPEED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst || init) begin
          mix     <= '0;
          mix_vld <= 1'b0;
        end else begin
          mix     <= mix_d;
          mix_vld <= din_vld;
        end
      end

      // R5
      stage_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !init) |=> mix_vld);
    end else begin : g_comb
      assign mix     = mix_d;
      assign mix_vld = din_vld;
    end
  endgenerate
endmodule

// File: rtl/crc_state.sv
module crc_state #(
  parameter int DEG = 16,
  parameter int DW = 8,
  parameter logic [DEG:0] POLY = 17'h11021,
  parameter logic [DEG:0] SEED = 17'h0FFFF,
  parameter bit AUGMENTED = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init,
  input  logic [DEG-1:0] mix,
  input  logic           mix_vld,
  output logic [DEG-1:0] crc_q,
  output logic           crc_vld
);
  import crc_par_pkg::*;
  localparam vec_t TAPS = MAXW'(POLY[DEG-1:0]);
  localparam logic [DEG-1:0] SEED_LOW = SEED[DEG-1:0];

  logic [DEG-1:0] crc_shift;

  // State advanced DW places with zero input; linear, so data adds via mix.
  always_comb
    crc_shift = DEG'(step_bits(MAXW'(crc_q), '0, TAPS, DEG, DW, 1'b1, AUGMENTED));

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q   <= SEED_LOW;
      crc_vld <= 1'b0;
    end else begin
      crc_vld <= mix_vld;
      if (mix_vld) crc_q <= crc_shift ^ mix;
    end
  end

  // R1
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> (crc_q == SEED_LOW));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!mix_vld && !init) |=> $stable(crc_q));
endmodule

// File: rtl/crc_par_engine.sv
module crc_par_engine #(
  parameter int DEG = 16,
  parameter int DW = 8,
  parameter logic [DEG:0] POLY = 17'h11021,
  parameter logic [DEG:0] SEED = 17'h0FFFF,
  parameter bit MSB_FIRST = 1'b1,
  parameter bit AUGMENTED = 1'b0,
  parameter bit SPEED = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init,
  input  logic           din_vld,
  input  logic [DW-1:0]  din,
  output logic [DEG-1:0] crc_out,
  output logic           crc_vld
);
  localparam int LAT = SPEED ? 2 : 1;

  logic [DEG-1:0] mix;
  logic           mix_vld;

  crc_premix #(
    .DEG(DEG), .DW(DW), .POLY(POLY), .MSB_FIRST(MSB_FIRST),
    .AUGMENTED(AUGMENTED), .SPEED(SPEED)
  ) u_premix (
    .clk(clk), .rst(rst), .init(init), .din_vld(din_vld), .din(din),
    .mix(mix), .mix_vld(mix_vld)
  );

  crc_state #(
    .DEG(DEG), .DW(DW), .POLY(POLY), .SEED(SEED), .AUGMENTED(AUGMENTED)
  ) u_state (
    .clk(clk), .rst(rst), .init(init), .mix(mix), .mix_vld(mix_vld),
    .crc_q(crc_out), .crc_vld(crc_vld)
  );

  // R8
  init_drop_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> !crc_vld);

  // R6
  vld_align_chk: assert property (@(posedge clk) disable iff (rst)
    crc_vld |-> $past(din_vld, LAT));
endmodule

// File: tb/tb_crc_par_engine.sv
`timescale 1ns/1ps
module tb_crc_par_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, init;
  logic va, vb, vc;
  logic [31:0] da;
  logic [7:0]  db;
  logic [0:0]  dc;
  logic [15:0] crc_a, crc_c;
  logic [31:0] crc_b;
  logic vld_a, vld_b, vld_c;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  localparam logic [64:0] P16 = 65'h11021;
  localparam logic [64:0] P32 = 65'h104C11DB7;
  localparam logic [31:0] VEC [8] = '{32'h12345670, 32'h00000000, 32'hFFFFFFFF,
    32'h80000001, 32'hA5A5A5A5, 32'h0000FFFF, 32'hDEADBEEF, 32'h13579BDF};

  crc_par_engine #(.DEG(16), .DW(32), .POLY(17'h11021), .SEED(17'h1FFFF),
    .MSB_FIRST(1'b1), .AUGMENTED(1'b0), .SPEED(1'b0)) dut (
    .clk(clk), .rst(rst), .init(init), .din_vld(va), .din(da),
    .crc_out(crc_a), .crc_vld(vld_a));

  crc_par_engine #(.DEG(32), .DW(8), .POLY(33'h104C11DB7), .SEED(33'h0FFFFFFFF),
    .MSB_FIRST(1'b0), .AUGMENTED(1'b0), .SPEED(1'b1)) dut_b (
    .clk(clk), .rst(rst), .init(init), .din_vld(vb), .din(db),
    .crc_out(crc_b), .crc_vld(vld_b));

  crc_par_engine #(.DEG(16), .DW(1), .POLY(17'h11021), .SEED(17'h10000),
    .MSB_FIRST(1'b1), .AUGMENTED(1'b1), .SPEED(1'b0)) dut_c (
    .clk(clk), .rst(rst), .init(init), .din_vld(vc), .din(dc),
    .crc_out(crc_c), .crc_vld(vld_c));

  // Reference: long division in a (deg+1)-bit window, one bit at a time.
  function automatic logic [63:0] ref_feed(logic [63:0] st, logic [63:0] w, int n,
                                           int deg, logic [64:0] poly, bit msbf, bit aug);
    logic [64:0] r;
    logic [63:0] mask;
    logic b;
    mask = (64'd1 << deg) - 64'd1;
    for (int i = 0; i < n; i++) begin
      b = msbf ? w[n-1-i] : w[i];
      r = {1'b0, st} << 1;
      if (aug) r[0] = b;
      else r[deg] = r[deg] ^ b;
      if (r[deg]) r = r ^ poly;
      st = r[63:0] & mask;
    end
    return st;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_init();
    @(negedge clk) init = 1'b1;
    @(negedge clk) init = 1'b0;
  endtask

  logic [63:0] run;
  logic [63:0] expb [33];

  initial begin
    rst = 1'b1; init = 1'b0; va = 0; vb = 0; vc = 0; da = '0; db = '0; dc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, seed top bit ignored
    chk("R1 seed A", crc_a, 64'hFFFF);
    chk("R1 seed B", crc_b, 64'hFFFFFFFF);
    chk("R1 seed C", crc_c, 64'h0);
    chk("R1 vld", {vld_a, vld_b, vld_c}, 64'h0);

    // R2 R3 R4 R6: table walk on the 32-bit MSB-first instance
    pulse_init();
    run = 64'hFFFF;
    for (int k = 0; k < 8; k++) begin
      da = VEC[k]; va = 1'b1;
      @(negedge clk);
      run = ref_feed(run, 64'(VEC[k]), 32, 16, P16, 1'b1, 1'b0);
      if (k == 0) chk("R2 known vector", crc_a, 64'hB1E4);
      chk("R3 R4 table word", crc_a, run);
      chk("R6 vld after word", vld_a, 64'h1);
    end
    va = 1'b0;
    // R3: hold while idle
    repeat (3) begin
      @(negedge clk);
      chk("R3 hold", crc_a, run);
      chk("R6 vld idle", vld_a, 64'h0);
    end

    // R4 R5: LSB-first byte stream through the speed stage
    pulse_init();
    expb[0] = 64'hFFFFFFFF;
    for (int k = 0; k < 32; k++)
      expb[k+1] = ref_feed(expb[k], 64'(VEC[k/4][8*(k%4) +: 8]), 8, 32, P32, 1'b0, 1'b0);
    for (int k = 0; k < 32; k++) begin
      db = VEC[k/4][8*(k%4) +: 8]; vb = 1'b1;
      @(negedge clk);
      if (k == 0) begin
        chk("R5 extra latency", vld_b, 64'h0);
        chk("R5 not yet absorbed", crc_b, 64'hFFFFFFFF);
      end else begin
        chk("R4 R5 stream", crc_b, expb[k]);
        chk("R5 R6 vld", vld_b, 64'h1);
      end
    end
    vb = 1'b0;
    @(negedge clk);
    chk("R5 last byte", crc_b, expb[32]);
    chk("R6 last vld", vld_b, 64'h1);
    @(negedge clk);
    chk("R6 vld drop", vld_b, 64'h0);
    chk("R3 hold B", crc_b, expb[32]);

    // R7: augmented 1-bit form, message then 16 zero bits
    pulse_init();
    for (int i = 0; i < 48; i++) begin
      dc = (i < 32) ? VEC[0][31-i] : 1'b0; vc = 1'b1;
      @(negedge clk);
    end
    vc = 1'b0;
    chk("R7 augmented", crc_c, ref_feed(64'h0, 64'h12345670, 32, 16, P16, 1'b1, 1'b0));

    // R8: init with a word in the same cycle
    pulse_init();
    init = 1'b1; va = 1'b1; da = 32'hCAFEF00D;
    @(negedge clk);
    init = 1'b0; va = 1'b0;
    chk("R8 same-cycle word dropped", crc_a, 64'hFFFF);
    chk("R8 vld low", vld_a, 64'h0);
    @(negedge clk);
    chk("R8 still seed", crc_a, 64'hFFFF);

    // R8: init while a byte sits in the mix stage
    pulse_init();
    db = 8'h5A; vb = 1'b1;
    @(negedge clk);
    vb = 1'b0; init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk("R8 staged word dropped", crc_b, 64'hFFFFFFFF);
    chk("R8 vld B", vld_b, 64'h0);
    @(negedge clk);
    chk("R8 staged stays dropped", crc_b, 64'hFFFFFFFF);
    chk("R8 vld B later", vld_b, 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule